// File: doc/BRIEF.md
# Gated PRBS15 Burst Generator

This block sources one transmit burst per reconfiguration slot of a fast circuit-switched optical link. A one-cycle start request launches the burst. The block first sends a run of alternating-bit words. These give a burst-mode receiver time to recover threshold and phase. A PRBS15 payload of 1024 or 2048 bytes follows. The receiving side can then measure bit errors on that payload.

Output words are valid-qualified. A done pulse marks the final payload word. Between bursts the data bus is held at zero while the optical path is re-pointed. The LFSR restarts from a fixed seed for every burst, so a checker at the far end can align to the pattern without searching for it. Word width, preamble length and the two payload sizes are parameters.

Top module: `burst_prbs_gen`

## Requirements
- R1: After reset, and before any start, `busy_o`, `valid_o` and `done_o` are 0 and `data_o` is all zeros.
- R2: A start request is sampled while idle. In the next cycle `busy_o` and `valid_o` are 1, and `data_o` carries the first of PRE_WORDS preamble words. Each preamble word is alternating 1,0,1,0... with its MSB at 1, which is 16'hAAAA for a 16-bit bus.
- R3: The payload follows the preamble directly. It is the PRBS15 sequence of x^15+x^14+1. A 15-bit register s starts at all ones. Each step yields the bit b = s[14] xor s[13] and then shifts, so that s becomes {s[13:0], b}. Each word takes DATA_W consecutive bits, and the first of them is placed at the MSB.
- R4: `long_i` is sampled together with the start request. A value of 0 gives a payload of SHORT_BYTES (1024) bytes and a value of 1 gives LONG_BYTES (2048) bytes. The payload has bytes*8/DATA_W words.
- R5: `done_o` is high for exactly one cycle. That cycle is the one in which the last payload word is on `data_o`.
- R6: `busy_o` stays high from the first preamble word through the last payload word. A start request seen while busy is ignored and does not restart or lengthen the burst.
- R7: Outside a burst, `valid_o` is 0 and `data_o` is all zeros.
- R8: The LFSR is reseeded at each burst. If a start is given in the cycle after `done_o`, a new burst begins. Its payload is identical to the payload of the previous burst of the same length.
- R9: A change of `long_i` during a burst has no effect on that burst's length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Burst request, sampled when idle |
| long_i | input | 1 | Payload size select: 0 short, 1 long |
| data_o | output | DATA_W | Burst data word, MSB first in time |
| valid_o | output | 1 | Marks `data_o` as burst content |
| busy_o | output | 1 | High for the whole burst |
| done_o | output | 1 | Marks the final payload word |

## Verification
The bench builds the block with DATA_W=16 and PRE_WORDS=3. With these values a short burst is 512 payload words and a long burst is 1024, which keeps full bursts of both sizes short enough to compare word by word against a model LFSR in the bench. A 16-bit bus makes each word take sixteen LFSR steps. The odd preamble length exercises a counter limit that is not a power of two. Start requests and size changes injected mid-burst, together with a back-to-back restart, bring the ignore and reseed rules within reach.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_PRE  = 2'd1,
    PH_PAY  = 2'd2
  } phase_e;

  localparam int unsigned LFSR_W = 15;
  localparam logic [LFSR_W-1:0] LFSR_SEED = '1;
endpackage

// File: rtl/prbs15_word.sv
module prbs15_word
  import burst_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              adv_i,
  output logic [DATA_W-1:0] word_o
);
  logic [LFSR_W-1:0] lfsr_q, lfsr_nxt;

  always_comb begin
    logic [LFSR_W-1:0] s;
    logic              b;
    s      = lfsr_q;
    word_o = '0;
    for (int i = 0; i < int'(DATA_W); i++) begin
      b = s[14] ^ s[13];
      word_o[DATA_W-1-i] = b;
      s = {s[13:0], b};
    end
    lfsr_nxt = s;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      lfsr_q <= LFSR_SEED;
    else if (load_i)  lfsr_q <= LFSR_SEED;
    else if (adv_i)   lfsr_q <= lfsr_nxt;
  end

  // R3
  lfsr_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lfsr_q != '0);
endmodule

// File: rtl/burst_seq.sv
module burst_seq
  import burst_pkg::*;
#(
  parameter int unsigned PRE_WORDS   = 4,
  parameter int unsigned SHORT_WORDS = 256,
  parameter int unsigned LONG_WORDS  = 512
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   start_i,
  input  logic   long_i,
  output phase_e phase_o,
  output logic   load_o,
  output logic   last_o
);
  localparam int unsigned MAX_CNT = (PRE_WORDS > LONG_WORDS) ? PRE_WORDS : LONG_WORDS;
  localparam int unsigned CNT_W   = $clog2(MAX_CNT + 1);
  localparam logic [CNT_W-1:0] PRE_LAST   = CNT_W'(PRE_WORDS - 1);
  localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_WORDS - 1);
  localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_WORDS - 1);

  phase_e           ph_q;
  logic [CNT_W-1:0] cnt_q;
  logic             long_q;

  assign phase_o = ph_q;
  assign load_o  = (ph_q == PH_IDLE) && start_i;
  assign last_o  = (ph_q == PH_PAY) && (cnt_q == (long_q ? LONG_LAST : SHORT_LAST));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      long_q <= 1'b0;
    end else begin
      unique case (ph_q)
        PH_IDLE: if (start_i) begin
          ph_q   <= PH_PRE;
          cnt_q  <= '0;
          long_q <= long_i;
        end
        PH_PRE: begin
          if (cnt_q == PRE_LAST) begin
            ph_q  <= PH_PAY;
            cnt_q <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        PH_PAY: begin
          if (last_o) begin
            ph_q  <= PH_IDLE;
            cnt_q <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  // R6
  pay_no_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_PAY && !last_o) |=> ph_q == PH_PAY);

  // R9
  size_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q != PH_IDLE) |=> $stable(long_q) || $past(last_o));
endmodule

// File: rtl/burst_prbs_gen.sv
module burst_prbs_gen
  import burst_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned PRE_WORDS   = 4,
  parameter int unsigned SHORT_BYTES = 1024,
  parameter int unsigned LONG_BYTES  = 2048
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              long_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int unsigned SHORT_WORDS = SHORT_BYTES * 8 / DATA_W;
  localparam int unsigned LONG_WORDS  = LONG_BYTES * 8 / DATA_W;

  logic [DATA_W-1:0] pre_pat;
  logic [DATA_W-1:0] prbs_word;
  phase_e            phase;
  logic              load, last;

  for (genvar g = 0; g < int'(DATA_W); g++) begin : g_pat
    assign pre_pat[g] = ((DATA_W - 1 - g) % 2) == 0;
  end

  burst_seq #(
    .PRE_WORDS  (PRE_WORDS),
    .SHORT_WORDS(SHORT_WORDS),
    .LONG_WORDS (LONG_WORDS)
  ) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .long_i (long_i),
    .phase_o(phase),
    .load_o (load),
    .last_o (last)
  );

  prbs15_word #(.DATA_W(DATA_W)) u_prbs (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load),
    .adv_i (phase == PH_PAY),
    .word_o(prbs_word)
  );

  always_comb begin
    unique case (phase)
      PH_PRE:  data_o = pre_pat;
      PH_PAY:  data_o = prbs_word;
      default: data_o = '0;
    endcase
  end

  assign busy_o  = phase != PH_IDLE;
  assign valid_o = busy_o;
  assign done_o  = last;

  // R5
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R7
  done_then_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o && data_o == '0);

  // R2
  pre_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> data_o == pre_pat);

  // R2
  start_launch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> busy_o && valid_o);
endmodule

// File: tb/sim_burst_prbs_gen.sv
module sim_burst_prbs_gen;
  localparam int unsigned DW = 16;
  localparam int unsigned PW = 3;
  localparam int unsigned SW = 1024 * 8 / DW;
  localparam int unsigned LW = 2048 * 8 / DW;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [DW-1:0] PAT = 16'hAAAA;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, long_sel = 1'b0;
  logic [DW-1:0] data;
  logic valid, busy, done;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_prbs_gen #(.DATA_W(DW), .PRE_WORDS(PW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .long_i(long_sel),
    .data_o(data), .valid_o(valid), .busy_o(busy), .done_o(done)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  // caller is positioned just after a negedge; burst launched here
  task automatic run_burst(input bit lng, input bit poke_start, input bit flip_len);
    logic [14:0] s = '1;
    int unsigned n = PW + (lng ? LW : SW);
    start = 1'b1;
    long_sel = lng;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < int'(n); i++) begin
      logic [DW-1:0] e;
      if (i < int'(PW)) e = PAT;
      else begin
        for (int k = 0; k < int'(DW); k++) begin
          logic b;
          b = s[14] ^ s[13];
          e[DW-1-k] = b;
          s = {s[13:0], b};
        end
      end
      if (i < int'(PW)) chk("R2 preamble", data, e);
      else chk("R3 payload", data, e);
      chk("R6 busy", {busy, valid}, 2'b11);
      chk("R5 done", done, i == int'(n) - 1);
      start = poke_start && (i == 5 || i == int'(n) - 1);
      if (flip_len && i == 7) long_sel = ~lng;
      @(negedge clk);
    end
    start = 1'b0;
    chk("R7 idle after burst", {busy, valid, done, data}, '0);
    if (poke_start) chk("R6 no restart", busy, 1'b0);
    if (flip_len) chk("R9 length kept", busy, 1'b0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {busy, valid, done, data}, '0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 idle after reset", {busy, valid, done, data}, '0);
  endtask

  task automatic t_short();
    run_burst(1'b0, 1'b0, 1'b0);   // R4 short
    repeat (4) @(negedge clk);
    chk("R7 idle gap", {valid, data}, '0);
  endtask

  task automatic t_long();
    run_burst(1'b1, 1'b0, 1'b0);   // R4 long
    @(negedge clk);
  endtask

  task automatic t_start_ignored();
    run_burst(1'b0, 1'b1, 1'b0);   // R6
    @(negedge clk);
  endtask

  task automatic t_len_change();
    run_burst(1'b0, 1'b0, 1'b1);   // R9 short burst, long_i raised mid-burst
    @(negedge clk);
    run_burst(1'b1, 1'b0, 1'b1);   // R9 long burst, long_i dropped mid-burst
    @(negedge clk);
  endtask

  task automatic t_back_to_back();
    run_burst(1'b0, 1'b0, 1'b0);
    run_burst(1'b0, 1'b0, 1'b0);   // R8 starts in cycle after done, reseeded
  endtask

  initial begin
    t_reset();
    t_short();
    t_long();
    t_start_ignored();
    t_len_change();
    t_back_to_back();
    finished = 1;
    summary();
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=complete");
      summary();
      $finish;
    end
  end
endmodule